// File: doc/BRIEF.md
# Timed Serial Control-Port Byte Writer

This block is a write-only master for a two-wire serial control port of the I2C kind. It sends one byte and then releases the bus. A single fast system clock runs the block. One tick counter, decoded per state, places every edge of the clock line and the data line. The minimum low time, high time, data setup, data hold, start hold and stop setup are each given in nanoseconds. Each one becomes a whole number of ticks, rounded up, using a clock-frequency parameter.

A one-cycle request with an 8-bit value begins a transaction while the block is idle. The block drives:
- a start condition,
- eight data bits, most significant first, taken from a shift register,
- a stop condition.

It then pulses done for one cycle. No acknowledge clock follows the eighth bit.

The data hold time can be longer than the clock high time. For that reason, the data line changes a fixed number of ticks into each clock low phase, not on the falling edge. Both lines are modelled as push-pull outputs.

Top module: `ctlport_byte_wr`

Tick counts used below, for frequency F and a minimum of N ns: T(N) = ceil(N·F / 1e9). The counts are:
- HIGH_T = T(600)
- STA_T = T(600)
- STO_T = T(600)
- SU_T = T(100)
- HD_T = T(900)
- DCH = max(HD_T − HIGH_T, 1)
- LOW_T = max(T(1300), DCH + SU_T)

## Requirements
- R1: During reset and while idle, scl_o = 1, sda_o = 1, busy = 0 and done = 0.
- R2: A request taken while idle makes sda_o fall on the next clock edge while scl_o stays 1. scl_o then falls exactly STA_T cycles after that sda_o fall.
- R3: Every scl_o low phase in a transaction lasts exactly LOW_T cycles. Every scl_o high phase of a data bit lasts exactly HIGH_T cycles.
- R4: Each transaction gives exactly nine scl_o rising edges: eight data bits and the stop rise, with no acknowledge clock. The sda_o values at the first eight rises equal tx_data, bit 7 first.
- R5: sda_o changes while scl_o is high only at start (a fall) and at stop (a rise). Any other change comes exactly DCH cycles after an scl_o fall. The new value is therefore present LOW_T − DCH cycles before the next rise, and it is held HIGH_T + DCH cycles after the previous rise.
- R6: After the eighth bit, sda_o is 0 during the final low phase. scl_o rises, and sda_o rises exactly STO_T cycles later.
- R7: done is 1 for exactly one cycle per transaction, in the cycle where sda_o rises at stop. busy is 1 from the cycle after the request until that cycle, where it reads 0.
- R8: A request while busy has no effect: the byte sent is still the first one, and no second transaction starts after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_start | input | 1 | One-cycle transaction request, taken only when idle |
| tx_data | input | 8 | Byte to send, captured with the request |
| scl_o | output | 1 | Serial clock line |
| sda_o | output | 1 | Serial data line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the stop condition completes |

## Verification
All 256 byte values are sent one after another. This pattern separates faults in bit order, bit selection and shifting, because every bit position is seen both as 0 and as 1 and both after a change and after no change. Values whose top bit is 0 leave sda_o low across the start-to-first-bit boundary. Values whose last bit is 0 leave it low into the stop phase. These cases separate correct change placement from changes that only happen to line up. On every sixteenth value, a second request with the inverted byte is issued in the middle of the transfer. This shows whether a request while busy leaks into the shift register or the sequencer.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LOW,
    ST_STOP_HIGH
  } cpw_state_e;

  // Minimum interval in ns to whole ticks, rounded up.
  function automatic int unsigned ns_to_ticks(input longint unsigned ns,
                                              input longint unsigned hz);
    longint unsigned t;
    t = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return t[31:0];
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cpw_timer.sv
module cpw_timer #(
  parameter int unsigned CW    = 8,
  parameter int unsigned MAX_T = 130
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_T));

endmodule

// File: rtl/cpw_shifter.sv
module cpw_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);

  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = din;
    else if (shift) sr_d = {sr_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[DATA_W-1];

  // R4
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == $past(din[DATA_W-1])));

  // R4
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (msb == $past(sr_q[DATA_W-2])));

endmodule

// File: rtl/cpw_seq.sv
module cpw_seq
  import cpw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CW     = 8,
  parameter int unsigned STA_T  = 60,
  parameter int unsigned LOW_T  = 130,
  parameter int unsigned HIGH_T = 60,
  parameter int unsigned DCH    = 30,
  parameter int unsigned STO_T  = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          msb,
  input  logic [CW-1:0] cnt,
  output logic          clr,
  output logic          load,
  output logic          shift,
  output logic          scl,
  output logic          sda,
  output logic          busy,
  output logic          done
);

  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] STA_END  = CW'(STA_T - 1);
  localparam logic [CW-1:0] LOW_END  = CW'(LOW_T - 1);
  localparam logic [CW-1:0] HIGH_END = CW'(HIGH_T - 1);
  localparam logic [CW-1:0] DCH_AT   = CW'(DCH - 1);
  localparam logic [CW-1:0] STO_END  = CW'(STO_T - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  cpw_state_e    state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          scl_q, scl_d, sda_q, sda_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    done_d  = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_START;
          sda_d   = 1'b0;
          bit_d   = '0;
          load    = 1'b1;
        end
      end
      ST_START: begin
        if (cnt == STA_END) begin
          state_d = ST_LOW;
          scl_d   = 1'b0;
        end
      end
      ST_LOW: begin
        if (cnt == DCH_AT) sda_d = msb;
        if (cnt == LOW_END) begin
          state_d = ST_HIGH;
          scl_d   = 1'b1;
        end
      end
      ST_HIGH: begin
        if (cnt == HIGH_END) begin
          scl_d = 1'b0;
          if (bit_q == LAST_BIT) begin
            state_d = ST_STOP_LOW;
          end else begin
            state_d = ST_LOW;
            bit_d   = bit_q + BW'(1);
            shift   = 1'b1;
          end
        end
      end
      ST_STOP_LOW: begin
        if (cnt == DCH_AT) sda_d = 1'b0;
        if (cnt == LOW_END) begin
          state_d = ST_STOP_HIGH;
          scl_d   = 1'b1;
        end
      end
      ST_STOP_HIGH: begin
        if (cnt == STO_END) begin
          state_d = ST_IDLE;
          sda_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign clr = (state_d != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
    end
  end

  assign scl  = scl_q;
  assign sda  = sda_q;
  assign done = done_q;
  assign busy = (state_q != ST_IDLE);

  // R2
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> (scl_q && !sda_q));

  // R5
  sda_high_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |->
      (state_q == ST_START || state_q == ST_IDLE));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && sda_q && scl_q));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_START) |=> (state_q != ST_START));

endmodule

// File: rtl/ctlport_byte_wr.sv
module ctlport_byte_wr
  import cpw_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LOW_NS  = 1300,
  parameter int unsigned HIGH_NS = 600,
  parameter int unsigned SU_NS   = 100,
  parameter int unsigned HD_NS   = 900,
  parameter int unsigned STA_NS  = 600,
  parameter int unsigned STO_NS  = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              scl_o,
  output logic              sda_o,
  output logic              busy,
  output logic              done
);

  localparam int unsigned HIGH_T = ns_to_ticks(HIGH_NS, CLK_HZ);
  localparam int unsigned SU_T   = ns_to_ticks(SU_NS, CLK_HZ);
  localparam int unsigned HD_T   = ns_to_ticks(HD_NS, CLK_HZ);
  localparam int unsigned STA_T  = ns_to_ticks(STA_NS, CLK_HZ);
  localparam int unsigned STO_T  = ns_to_ticks(STO_NS, CLK_HZ);
  localparam int unsigned DCH    = (HD_T > HIGH_T + 1) ? (HD_T - HIGH_T) : 1;
  localparam int unsigned LOW_T  = umax(ns_to_ticks(LOW_NS, CLK_HZ), DCH + SU_T);
  localparam int unsigned MAX_T  = umax(umax(LOW_T, HIGH_T), umax(STA_T, STO_T));
  localparam int unsigned CW     = $clog2(MAX_T + 1);

  logic          rst_meta_q, rst_sync_q;
  logic          clr, load, shift, msb;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cpw_timer #(.CW(CW), .MAX_T(MAX_T)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (clr),
    .cnt   (cnt)
  );

  cpw_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (load),
    .shift (shift),
    .din   (tx_data),
    .msb   (msb)
  );

  cpw_seq #(
    .DATA_W (DATA_W),
    .CW     (CW),
    .STA_T  (STA_T),
    .LOW_T  (LOW_T),
    .HIGH_T (HIGH_T),
    .DCH    (DCH),
    .STO_T  (STO_T)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (tx_start),
    .msb   (msb),
    .cnt   (cnt),
    .clr   (clr),
    .load  (load),
    .shift (shift),
    .scl   (scl_o),
    .sda   (sda_o),
    .busy  (busy),
    .done  (done)
  );

endmodule

// File: tb/ctlport_byte_wr_test.sv
module ctlport_byte_wr_test;

  localparam longint unsigned F = 10_000_000;

  function automatic int tk(input longint unsigned ns);
    longint unsigned t;
    t = (ns * F + 64'd999_999_999) / 64'd1_000_000_000;
    return int'(t);
  endfunction

  localparam int HIGH_T = tk(600);
  localparam int STA_T  = tk(600);
  localparam int STO_T  = tk(600);
  localparam int SU_T   = tk(100);
  localparam int HD_T   = tk(900);
  localparam int DCH    = (HD_T - HIGH_T > 1) ? HD_T - HIGH_T : 1;
  localparam int LOW_T  = (tk(1300) > DCH + SU_T) ? tk(1300) : DCH + SU_T;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_start;
  logic [7:0] tx_data;
  logic scl_o, sda_o, busy, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ctlport_byte_wr #(.CLK_HZ(F)) uut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_data(tx_data),
    .scl_o(scl_o), .sda_o(sda_o), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // line monitor, samples at the falling clock edge
  logic mon_en = 1'b0;
  logic p_scl, p_sda;
  int   tnow, t_rise, t_fall, t_sda;
  int   nrise, nhchg, ndone, nstart, ntx, bbad;
  logic first_fall, in_tx;
  logic [7:0] rx;

  always @(negedge clk) begin
    if (mon_en) begin
      tnow++;
      if ((sda_o != p_sda) && p_scl && scl_o) begin
        if (!sda_o) begin
          in_tx = 1'b1; rx = '0; nrise = 0; nhchg = 1; ndone = 0; bbad = 0;
          first_fall = 1'b1; nstart++;
        end else begin
          nhchg++;
          chk("R6 stop setup", tnow - t_rise, STO_T);
        end
        t_sda = tnow;
      end else if (sda_o != p_sda) begin
        if (scl_o != p_scl) chk("R5 sda moved with scl", 1, 0);
        else chk("R5 change offset after scl fall", tnow - t_fall, DCH);
        t_sda = tnow;
      end
      if ((scl_o != p_scl) && scl_o) begin
        chk("R3 low phase", tnow - t_fall, LOW_T);
        if (t_sda > t_fall) chk("R5 setup", tnow - t_sda, LOW_T - DCH);
        if (nrise < 8) rx = {rx[6:0], sda_o};
        nrise++;
        t_rise = tnow;
      end
      if ((scl_o != p_scl) && !scl_o) begin
        if (first_fall) begin
          chk("R2 start hold", tnow - t_sda, STA_T);
          first_fall = 1'b0;
        end else begin
          chk("R3 high phase", tnow - t_rise, HIGH_T);
        end
        t_fall = tnow;
      end
      if (done) begin
        ndone++;
        chk("R7 done on stop rise", int'((sda_o != p_sda) && sda_o), 1);
        chk("R7 busy low with done", int'(busy), 0);
        in_tx = 1'b0;
        ntx++;
      end else if (in_tx && !busy) begin
        bbad++;
      end
      p_scl = scl_o;
      p_sda = sda_o;
    end
  end

  task automatic send(input logic [7:0] v, input logic poke);
    int n0;
    int s0;
    n0 = ntx;
    s0 = nstart;
    @(negedge clk);
    tx_start = 1'b1;
    tx_data  = v;
    @(negedge clk);
    tx_start = 1'b0;
    tx_data  = 8'h00;
    chk("R7 busy after request", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      tx_start = 1'b1;
      tx_data  = ~v;
      @(negedge clk);
      tx_start = 1'b0;
    end
    while (ntx == n0) @(posedge clk);
    chk(poke ? "R8 byte kept" : "R4 byte value", int'(rx), int'(v));
    chk("R4 rising edges", nrise, 9);
    chk("R5 changes while high", nhchg, 2);
    chk("R7 done cycles", ndone, 1);
    chk("R7 busy gaps", bbad, 0);
    repeat (4) @(negedge clk);
    chk("R8 one start only", nstart - s0, 1);
    chk("R8 idle after done", int'({scl_o, sda_o, busy}), 3'b110);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_start = 1'b0;
    tx_data = 8'h00;
    tnow = 0; t_rise = 0; t_fall = 0; t_sda = 0;
    nrise = 0; nhchg = 0; ndone = 0; nstart = 0; ntx = 0; bbad = 0;
    first_fall = 1'b0; in_tx = 1'b0; rx = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset lines", int'({scl_o, sda_o, busy, done}), 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle lines", int'({scl_o, sda_o, busy, done}), 4'b1100);
    p_scl = scl_o;
    p_sda = sda_o;
    mon_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      send(8'(v), (v % 16) == 5);
    end
    chk("R1 idle at end", int'({scl_o, sda_o, busy, done}), 4'b1100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule